// File: doc/BRIEF.md
# Host Comport Register Interface

This block lets a host bus master trade 32-bit words with a DSP across a byte-wide comport link whose direction is shared between the two sides. The host sees three register addresses. The data address is written to load an outgoing word and read to fetch an incoming word. The control address is written to drive a module reset and read to get status. The interrupt address is write-only and holds the enables and the clear-by-one controls. A single combined interrupt request goes to the host.

The link carries one word as four bytes, least significant byte first. Outgoing bytes use a valid/ready handshake (`tx_valid` and `tx_ready`). Incoming bytes use another (`rx_valid` and `rx_ready`). One output, `link_dir`, shows which side drives. A state machine with four states owns the link:
- IDLE waits for work.
- TURN is a single quiet cycle spent reversing the direction.
- SEND streams the held output word.
- RECV gathers an incoming word.

The transitions are:
- IDLE goes to SEND or RECV directly when the direction already suits the chosen job, and to TURN otherwise.
- TURN always goes on to the job it was reversing for.
- SEND returns to IDLE once its fourth byte is accepted.
- RECV returns to IDLE once its fourth byte is taken.

When both sides want the link in the same IDLE cycle, the side that was not served most recently goes first.

Top module: `hcp_host_port`

## Requirements
- R1: During and after reset the status word (control address 1 read) is zero, `host_irq` is low, all enables are zero and `link_dir` is 0 (DSP drives).
- R2: A write to address 0 while the output-full bit (status bit 0) is 0 stores the word and sets status bit 0 from the next cycle.
- R3: A write to address 0 while status bit 0 is 1 is ignored; the held word is not replaced and no extra bytes appear on the link.
- R4: The held word leaves as four bytes on `tx_byte`, least significant first, one per cycle where `tx_valid` and `tx_ready` are both high. After the fourth, status bit 0 clears and the transmit-done flag (status bit 4) sets.
- R5: Four bytes taken while `rx_valid` and `rx_ready` are high form a word, least significant byte first. After the fourth, reading address 0 returns that word, and the input-full bit (status bit 1) and the receive flag (status bit 5) are set. `rx_ready` stays low while status bit 1 is set.
- R6: Reading address 0 clears status bit 1, after which the next word can be received.
- R7: A rising edge on `dsp_irq` sets status bit 6, and a rising edge on `aux_irq` sets status bit 7.
- R8: Status bits 7:4 are sticky. Writing address 2 with bit 8+i set clears flag i (status bit 4+i). Writing 0 there leaves the flag unchanged. A new event in the same cycle wins over a clear.
- R9: Every write to address 2 loads the enables from bits 3:0, bit i enabling flag i. `host_irq` is high exactly when some flag is set with its enable set.
- R10: Writing address 1 with bit 0 = 1 drives `mod_rst` high until a write with bit 0 = 0. `mod_rst` is also high whenever `rst` is high.
- R11: `tx_valid` is high only while `link_dir` is 1 and `rx_ready` only while it is 0. A direction change is preceded by a cycle with neither high. Status bit 2 reports `link_dir`.
- R12: When a pending output word and a DSP request (`dsp_req` with status bit 1 clear) meet in IDLE, the side not served by the last completed transfer is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effect on address 0) |
| host_addr | input | 2 | Register address: 0 data, 1 control/status, 2 interrupt control |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for the current address |
| host_irq | output | 1 | Combined interrupt request |
| mod_rst | output | 1 | Reset toward attached modules |
| link_dir | output | 1 | 1 when the host side drives the link |
| tx_byte | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | DSP accepts the outgoing byte |
| rx_byte | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block accepts the incoming byte |
| dsp_req | input | 1 | DSP wants to send a word |
| dsp_irq | input | 1 | DSP host-interrupt line |
| aux_irq | input | 1 | Second interrupt source line |

## Verification
The bench goes after five corner cases:
- A second data write issued while a word is stalled on the link. A design that overwrote the held word would put foreign bytes on the link, and the byte scoreboard would reject them.
- A DSP sender that keeps offering bytes while the input register is still full. A design that ignored the full bit would raise `rx_ready` and lose the unread word.
- Clear writes that carry zero in the clear field. A design that cleared every flag on any write would let the interrupt vanish.
- Enables that are off while a flag is set. A design that did not gate the flags would raise `host_irq` anyway.
- Simultaneous requests from both sides, arranged once after a receive and once after a send. A design without alternation would pick the same side both times and fail one of the two order checks.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TURN,
        ST_SEND,
        ST_RECV
    } link_state_t;

    // register addresses
    localparam int unsigned REG_DATA = 0;
    localparam int unsigned REG_CTRL = 1;
    localparam int unsigned REG_IRQ  = 2;

    // status word bit positions
    localparam int unsigned ST_OBF     = 0;
    localparam int unsigned ST_IBF     = 1;
    localparam int unsigned ST_DIR     = 2;
    localparam int unsigned ST_FLAG_LO = 4;

    // interrupt control word fields
    localparam int unsigned IC_EN_LO  = 0;
    localparam int unsigned IC_CLR_LO = 8;

    // control word
    localparam int unsigned CT_RST = 0;

endpackage

// File: rtl/hcp_edge_det.sv
module hcp_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= lvl[g];
            end
        end
        assign rise[g] = lvl[g] & ~prev_q[g];
    end

endmodule

// File: rtl/hcp_irq_unit.sv
module hcp_irq_unit #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic         ctl_wr,
    input  logic [N-1:0] clr_mask,
    input  logic [N-1:0] en_val,
    output logic [N-1:0] flags,
    output logic         irq
);

    logic [N-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (ctl_wr) begin
            en_q <= en_val;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[g] <= 1'b0;
            end else if (set_ev[g]) begin
                flags[g] <= 1'b1;
            end else if (ctl_wr && clr_mask[g]) begin
                flags[g] <= 1'b0;
            end
        end
    end

    assign irq = |(flags & en_q);

endmodule

// File: rtl/hcp_link_fsm.sv
module hcp_link_fsm
    import hcp_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             out_pending,
    input  logic             in_blocked,
    input  logic             dsp_req,
    input  logic             tx_ready,
    input  logic             rx_valid,
    output logic             tx_valid,
    output logic             rx_ready,
    output logic             link_dir,
    output logic [CNT_W-1:0] lane,
    output logic             tx_done,
    output logic             rx_take,
    output logic             rx_done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

    link_state_t      state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             dir_q, dir_n;
    logic             tgt_q, tgt_n;
    logic             last_tx_q, last_tx_n;

    logic want_tx, want_rx, pick_tx, pick_rx, moving, at_last;

    assign want_tx = out_pending;
    assign want_rx = dsp_req && !in_blocked;
    assign pick_tx = want_tx && (!want_rx || !last_tx_q);
    assign pick_rx = want_rx && !pick_tx;
    assign at_last = (cnt_q == LAST);
    assign moving  = ((state_q == ST_SEND) && tx_ready) ||
                     ((state_q == ST_RECV) && rx_valid);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            dir_q     <= 1'b0;
            tgt_q     <= 1'b0;
            last_tx_q <= 1'b0;
        end else begin
            state_q   <= state_n;
            cnt_q     <= cnt_n;
            dir_q     <= dir_n;
            tgt_q     <= tgt_n;
            last_tx_q <= last_tx_n;
        end
    end

    // next state
    always_comb begin
        state_n   = state_q;
        dir_n     = dir_q;
        tgt_n     = tgt_q;
        last_tx_n = last_tx_q;
        cnt_n     = cnt_q;
        if (moving) begin
            cnt_n = at_last ? '0 : cnt_q + 1'b1;
        end
        unique case (state_q)
            ST_IDLE: begin
                if (pick_tx || pick_rx) begin
                    tgt_n = pick_tx;
                    if (pick_tx == dir_q) begin
                        state_n = pick_tx ? ST_SEND : ST_RECV;
                    end else begin
                        state_n = ST_TURN;
                    end
                end
            end
            ST_TURN: begin
                dir_n   = tgt_q;
                state_n = tgt_q ? ST_SEND : ST_RECV;
            end
            ST_SEND: begin
                if (tx_ready && at_last) begin
                    state_n   = ST_IDLE;
                    last_tx_n = 1'b1;
                end
            end
            ST_RECV: begin
                if (rx_valid && at_last) begin
                    state_n   = ST_IDLE;
                    last_tx_n = 1'b0;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_valid = (state_q == ST_SEND);
        rx_ready = (state_q == ST_RECV);
        tx_done  = (state_q == ST_SEND) && tx_ready && at_last;
        rx_take  = (state_q == ST_RECV) && rx_valid;
        rx_done  = (state_q == ST_RECV) && rx_valid && at_last;
        link_dir = dir_q;
        lane     = cnt_q;
    end

endmodule

// File: rtl/hcp_host_port.sv
module hcp_host_port
    import hcp_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int BYTE_W  = 8,
    parameter int ADDR_W  = 2,
    parameter int N_FLAGS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_irq,
    output logic              mod_rst,
    output logic              link_dir,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              dsp_req,
    input  logic              dsp_irq,
    input  logic              aux_irq
);

    localparam int LANES = DATA_W / BYTE_W;
    localparam int CNT_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic wr_out, rd_in, wr_ctl, wr_irq;
    assign wr_out = host_wr && (host_addr == ADDR_W'(REG_DATA));
    assign rd_in  = host_rd && (host_addr == ADDR_W'(REG_DATA));
    assign wr_ctl = host_wr && (host_addr == ADDR_W'(REG_CTRL));
    assign wr_irq = host_wr && (host_addr == ADDR_W'(REG_IRQ));

    logic [DATA_W-1:0] out_q, in_q, asm_q, asm_next;
    logic              obf_q, ibf_q, ctl_rst_q;
    logic [CNT_W-1:0]  lane;
    logic              tx_done, rx_take, rx_done;
    logic [1:0]        irq_rise;
    logic [N_FLAGS-1:0] flags;

    hcp_link_fsm #(
        .LANES (LANES),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .out_pending (obf_q),
        .in_blocked  (ibf_q),
        .dsp_req     (dsp_req),
        .tx_ready    (tx_ready),
        .rx_valid    (rx_valid),
        .tx_valid    (tx_valid),
        .rx_ready    (rx_ready),
        .link_dir    (link_dir),
        .lane        (lane),
        .tx_done     (tx_done),
        .rx_take     (rx_take),
        .rx_done     (rx_done)
    );

    hcp_edge_det #(
        .N (2)
    ) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({aux_irq, dsp_irq}),
        .rise (irq_rise)
    );

    hcp_irq_unit #(
        .N (N_FLAGS)
    ) u_irq (
        .clk      (clk),
        .rst      (rst),
        .set_ev   ({irq_rise, rx_done, tx_done}),
        .ctl_wr   (wr_irq),
        .clr_mask (host_wdata[IC_CLR_LO +: N_FLAGS]),
        .en_val   (host_wdata[IC_EN_LO +: N_FLAGS]),
        .flags    (flags),
        .irq      (host_irq)
    );

    // output word holding register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            obf_q <= 1'b0;
        end else if (wr_out && !obf_q) begin
            out_q <= host_wdata;
            obf_q <= 1'b1;
        end else if (tx_done) begin
            obf_q <= 1'b0;
        end
    end

    assign tx_byte = out_q[lane*BYTE_W +: BYTE_W];

    // incoming word assembly
    always_comb begin
        asm_next = asm_q;
        asm_next[lane*BYTE_W +: BYTE_W] = rx_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            asm_q <= '0;
            in_q  <= '0;
            ibf_q <= 1'b0;
        end else begin
            if (rx_take) begin
                asm_q <= asm_next;
            end
            if (rx_done) begin
                in_q  <= asm_next;
                ibf_q <= 1'b1;
            end else if (rd_in) begin
                ibf_q <= 1'b0;
            end
        end
    end

    // module reset control
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_rst_q <= 1'b0;
        end else if (wr_ctl) begin
            ctl_rst_q <= host_wdata[CT_RST];
        end
    end

    assign mod_rst = rst | ctl_rst_q;

    // read path
    logic [DATA_W-1:0] status;
    always_comb begin
        status = '0;
        status[ST_OBF] = obf_q;
        status[ST_IBF] = ibf_q;
        status[ST_DIR] = link_dir;
        status[ST_FLAG_LO +: N_FLAGS] = flags;
    end

    always_comb begin
        if (host_addr == ADDR_W'(REG_DATA)) begin
            host_rdata = in_q;
        end else if (host_addr == ADDR_W'(REG_CTRL)) begin
            host_rdata = status;
        end else begin
            host_rdata = '0;
        end
    end

endmodule

// File: rtl/hcp_host_port_chk.sv
module hcp_host_port_chk #(
    parameter int DATA_W  = 32,
    parameter int N_FLAGS = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_out,
    input logic               wr_irq,
    input logic [DATA_W-1:0]  host_wdata,
    input logic               obf_q,
    input logic               ibf_q,
    input logic [DATA_W-1:0]  out_q,
    input logic               tx_done,
    input logic               tx_valid,
    input logic               rx_ready,
    input logic               link_dir,
    input logic               host_irq,
    input logic               mod_rst,
    input logic [N_FLAGS-1:0] flags
);

    logic [N_FLAGS-1:0] clr_vec;
    assign clr_vec = wr_irq ? host_wdata[8 +: N_FLAGS] : '0;

    p_obf_set_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_out && !obf_q) |=> obf_q);

    p_no_overwrite_r3: assert property (@(posedge clk) disable iff (rst)
        (obf_q && !tx_done) |=> $stable(out_q));

    p_ibf_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        ibf_q |-> !rx_ready);

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((($past(flags) & ~$past(clr_vec)) & ~flags) == '0));

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> (flags != '0));

    p_sysrst_r10: assert property (@(posedge clk)
        rst |-> mod_rst);

    p_tx_dir_r11: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> link_dir);

    p_rx_dir_r11: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> !link_dir);

    p_quiet_turn_r11: assert property (@(posedge clk) disable iff (rst)
        (link_dir != $past(link_dir)) |-> ($past(!tx_valid && !rx_ready)));

endmodule

bind hcp_host_port hcp_host_port_chk #(
    .DATA_W  (DATA_W),
    .N_FLAGS (N_FLAGS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_out     (wr_out),
    .wr_irq     (wr_irq),
    .host_wdata (host_wdata),
    .obf_q      (obf_q),
    .ibf_q      (ibf_q),
    .out_q      (out_q),
    .tx_done    (tx_done),
    .tx_valid   (tx_valid),
    .rx_ready   (rx_ready),
    .link_dir   (link_dir),
    .host_irq   (host_irq),
    .mod_rst    (mod_rst),
    .flags      (flags)
);

// File: tb/hcp_host_port_test.sv
module hcp_host_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_irq, mod_rst, link_dir, tx_valid, rx_ready;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        dsp_req = 1'b0;
    logic        dsp_irq = 1'b0;
    logic        aux_irq = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [7:0]  tx_exp[$];
    logic [31:0] rx_exp[$];

    always #10 clk = ~clk;

    hcp_host_port uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_irq(host_irq), .mod_rst(mod_rst), .link_dir(link_dir),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .dsp_req(dsp_req), .dsp_irq(dsp_irq), .aux_irq(aux_irq)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // driver: host word out, expected bytes into the scoreboard
    task automatic push_word(input logic [31:0] w);
        for (int i = 0; i < 4; i++) tx_exp.push_back(w[i*8 +: 8]);
        wr(2'd0, w);
    endtask

    // DSP sender model, entered at a falling edge
    task automatic dsp_send(input logic [31:0] w);
        rx_exp.push_back(w);
        dsp_req = 1'b1;
        for (int i = 0; i < 4; i++) begin
            rx_byte  = w[i*8 +: 8];
            rx_valid = 1'b1;
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        dsp_req  = 1'b0;
    endtask

    task automatic read_word(input string req);
        logic [31:0] d, e;
        rd(2'd0, d);
        e = (rx_exp.size() != 0) ? rx_exp.pop_front() : 32'hDEAD_BEEF;
        chk(d == e, req, d, e);
    endtask

    task automatic drain();
        while (tx_exp.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: DSP receiver side of the scoreboard
    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            if (tx_exp.size() == 0) begin
                chk(1'b0, "R3 unexpected byte", {24'd0, tx_byte}, 32'd0);
            end else begin
                logic [7:0] e;
                e = tx_exp.pop_front();
                chk(tx_byte == e, "R4 byte order", {24'd0, tx_byte}, {24'd0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] s;
        logic        first_tx;
        repeat (3) @(negedge clk);
        chk(mod_rst == 1'b1, "R10 reset drives mod_rst", {31'd0, mod_rst}, 32'd1);
        rst = 1'b0;

        // R1 reset state
        rd(2'd1, s);
        chk(s == 32'd0, "R1 status after reset", s, 32'd0);
        chk(host_irq == 1'b0, "R1 irq after reset", {31'd0, host_irq}, 32'd0);
        chk(link_dir == 1'b0, "R1 dir after reset", {31'd0, link_dir}, 32'd0);

        // R2/R3 stalled word and ignored overwrite
        push_word(32'hA1B2_C3D4);
        rd(2'd1, s);
        chk(s[0] == 1'b1, "R2 output full set", s, 32'd1);
        wr(2'd0, 32'h0BAD_0BAD);
        rd(2'd1, s);
        chk(s[4] == 1'b0, "R3 still pending", s, 32'd0);
        @(negedge clk);
        tx_ready = 1'b1;
        drain();
        rd(2'd1, s);
        chk(s[0] == 1'b0 && s[4] == 1'b1, "R4 full clear, done flag", s, 32'h14);
        chk(s[2] == 1'b1, "R11 status dir after send", s, 32'h14);
        chk(tx_exp.size() == 0, "R3 no extra bytes", tx_exp.size(), 0);

        // R8/R9 enables and clears
        wr(2'd2, 32'h0000_0000);
        chk(host_irq == 1'b0, "R9 gated off", {31'd0, host_irq}, 32'd0);
        wr(2'd2, 32'h0000_0001);
        chk(host_irq == 1'b1, "R9 enabled flag", {31'd0, host_irq}, 32'd1);
        wr(2'd2, 32'h0000_0001);
        rd(2'd1, s);
        chk(s[4] == 1'b1, "R8 zero clear keeps flag", s, 32'h10);
        wr(2'd2, 32'h0000_0101);
        rd(2'd1, s);
        chk(s[4] == 1'b0 && host_irq == 1'b0, "R8 write-one clear", s, 32'h0);

        // R5/R6 receive, blocked while full
        @(negedge clk);
        dsp_send(32'h1122_3344);
        repeat (2) @(negedge clk);
        rd(2'd1, s);
        chk(s[1] == 1'b1 && s[5] == 1'b1, "R5 input full and flag", s, 32'h22);
        dsp_req = 1'b1; rx_valid = 1'b1; rx_byte = 8'hEE;
        repeat (5) @(negedge clk);
        chk(rx_ready == 1'b0, "R5 not ready while full", {31'd0, rx_ready}, 32'd0);
        read_word("R5 received word");
        dsp_send(32'h5566_7788);
        repeat (2) @(negedge clk);
        read_word("R6 next word after read");
        rd(2'd1, s);
        chk(s[1] == 1'b0, "R6 input full cleared", s, 32'd0);

        // R7 external interrupt edges, R9 per-source enable
        @(negedge clk); dsp_irq = 1'b1; aux_irq = 1'b1;
        repeat (2) @(negedge clk); dsp_irq = 1'b0; aux_irq = 1'b0;
        rd(2'd1, s);
        chk(s[7:6] == 2'b11, "R7 dsp and aux flags", s, 32'hE0);
        wr(2'd2, 32'h0000_0004);
        chk(host_irq == 1'b1, "R9 dsp flag enabled", {31'd0, host_irq}, 32'd1);
        wr(2'd2, 32'h0000_0404);
        chk(host_irq == 1'b0, "R8 dsp flag cleared", {31'd0, host_irq}, 32'd0);

        // R10 module reset by control write
        wr(2'd1, 32'h1);
        chk(mod_rst == 1'b1, "R10 control reset on", {31'd0, mod_rst}, 32'd1);
        wr(2'd1, 32'h0);
        chk(mod_rst == 1'b0, "R10 control reset off", {31'd0, mod_rst}, 32'd0);

        // R12 arbitration: last served was receive, send goes first
        push_word(32'hCAFE_0001);
        dsp_req = 1'b1; rx_valid = 1'b1; rx_byte = 8'h99;
        while (!tx_valid && !rx_ready) @(negedge clk);
        first_tx = tx_valid;
        chk(first_tx == 1'b1, "R12 send first after receive", {31'd0, first_tx}, 32'd1);
        dsp_send(32'h0102_0304);
        drain();
        read_word("R12 word after contention");

        // lone send, then contention: receive first
        push_word(32'h7777_8888);
        drain();
        push_word(32'hBEEF_0002);
        dsp_req = 1'b1; rx_valid = 1'b1; rx_byte = 8'h99;
        while (!tx_valid && !rx_ready) @(negedge clk);
        first_tx = tx_valid;
        chk(first_tx == 1'b0, "R12 receive first after send", {31'd0, first_tx}, 32'd0);
        dsp_send(32'h0A0B_0C0D);
        drain();
        read_word("R12 second contention word");
        chk(tx_exp.size() == 0, "R4 scoreboard empty", tx_exp.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule